// File: doc/BRIEF.md
# Infrared Line Status and Control Registers

This block is the host-facing register file of an infrared communications engine. It has two line control registers at fixed addresses and eight line status registers that share one host address. A write to the shared address with bit 7 low loads a 3-bit pointer. Later reads at that address return the status register the pointer selects. The pointer itself can never be read back. A write to the shared address with bit 7 high is a clear command. It clears the latched error bits of status register 0 at the positions written as one, and it does not move the pointer.

Error pulses arrive from the receive and transmit datapaths and are latched into status register 0. Several control bits are cleared by hardware events. The abort request clears at end of frame. The data-done flag clears at end of frame, but only when the FIFO is empty. The FIFO reset request clears once the FIFO has reinitialised. The mode field clears when a consumer-IR message completes. Internal loopback can only be turned on while the mode field is zero.

Top module: `ir_line_regs`

## Requirements
- R1: After reset, every control bit, every latched error bit, the pointer and loopback are zero.
- R2: A write at the status address (default 6) with bit 7 = 0 loads the pointer from bits 2:0. A read there returns status register 0 when the pointer is 0. When the pointer is 1 it returns {5'b0, loopback, mode≠0, raw receive} in bits 7:0. Pointers 2 to 7 read as zero.
- R3: A receive CRC error pulse sets bit 3 of status register 0.
- R4: Bit 2 of status register 0 (frame abort) is set by any of four causes: a write of 1 to the abort bit, a transmit underrun while data-done is 0, a receive overrun, or a receive framing error. An underrun while data-done is 1 does not set it.
- R5: A receive framing error also sets bit 4 of status register 0.
- R6: A write at the status address with bit 7 = 1 and the pointer at 0 clears the latched bits of status register 0 wherever bits 6:0 hold a one. With any other pointer value it changes nothing. Latched bits otherwise hold.
- R7: Control register A sits at address 4. Its bits are FIFO reset at 7, fast output at 6, general-purpose data at 5, raw transmit at 4, live raw receive at 3 (read-only), abort at 2 and data-done at 1. Bit 0 reads 0. Bits 7, 6, 5, 4, 2 and 1 drive the matching outputs.
- R8: An end-of-frame pulse clears abort. It clears data-done only if the FIFO is empty in that cycle.
- R9: A terminal-count pulse sets data-done only while the mode field is 2'b10 (transmit). The receive mode is 2'b01 and the combined mode is 2'b11.
- R10: A FIFO-reinitialised pulse clears the FIFO reset bit.
- R11: Control register B sits at address 5, with the mode field at bits 7:6 and loopback at bit 0. A consumer-IR completion pulse clears the mode field. Otherwise the mode changes only by a host write.
- R12: A write of 1 to loopback takes effect only if both the stored mode and the written mode are zero. In every other case the write leaves loopback at 0.
- R13: When a host write and a hardware event hit the same bit in the same cycle, the hardware event wins. A set beats a clear command, and an end-of-frame, terminal-count, reinitialised or completion pulse beats the host value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr` (combinational) |
| raw_rx_i | input | 1 | Live infrared detector level |
| fifo_empty_i | input | 1 | FIFO empty flag |
| crc_err_i | input | 1 | Receive CRC error pulse |
| frame_err_i | input | 1 | Receive framing error pulse |
| overrun_i | input | 1 | Receive FIFO overrun pulse |
| underrun_i | input | 1 | Transmit FIFO underrun pulse |
| tc_i | input | 1 | DMA terminal-count pulse |
| eof_i | input | 1 | End-of-frame pulse |
| fifo_init_done_i | input | 1 | FIFO reinitialisation complete pulse |
| cir_done_i | input | 1 | Consumer-IR message complete pulse |
| fifo_reset_o | output | 1 | FIFO reset request |
| fast_o | output | 1 | General-purpose fast output |
| gp_o | output | 1 | General-purpose data output |
| raw_tx_o | output | 1 | Raw emitter drive |
| abort_o | output | 1 | Transmit abort request |
| data_done_o | output | 1 | End-of-valid-data flag |
| mode_o | output | 2 | Transmitter/receiver enable field |
| loopback_o | output | 1 | Internal loopback enable |

## Verification
The assertions take the event inputs as single-cycle pulses sampled on the clock, and they take the host bus as one write per cycle. Any mix of events in one cycle is allowed. Since hardware must win every such overlap, the stimulus does not avoid collisions. It draws events, writes and clear commands independently every cycle, so writes that coincide with end-of-frame, terminal-count or completion pulses occur often. A behavioural model in the bench predicts every output and the read data each cycle. Directed steps before the random run reach the cases that random draws rarely hit: an underrun with data-done set, loopback refused under a nonzero mode, and a set meeting a clear.

// File: rtl/ir_line_regs.sv
module ir_line_regs #(
  parameter int ADDR_W    = 3,
  parameter int LCRA_ADDR = 4,
  parameter int LCRB_ADDR = 5,
  parameter int STAT_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              raw_rx_i,
  input  logic              fifo_empty_i,
  input  logic              crc_err_i,
  input  logic              frame_err_i,
  input  logic              overrun_i,
  input  logic              underrun_i,
  input  logic              tc_i,
  input  logic              eof_i,
  input  logic              fifo_init_done_i,
  input  logic              cir_done_i,
  output logic              fifo_reset_o,
  output logic              fast_o,
  output logic              gp_o,
  output logic              raw_tx_o,
  output logic              abort_o,
  output logic              data_done_o,
  output logic [1:0]        mode_o,
  output logic              loopback_o
);

  localparam logic [ADDR_W-1:0] A_LCRA = ADDR_W'(LCRA_ADDR);
  localparam logic [ADDR_W-1:0] A_LCRB = ADDR_W'(LCRB_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic [2:0] ptr_q;
  logic       frm_q, crc_q, abt_q;
  logic       fiforst_q, fast_q, gp_q, rawtx_q, abort_q, dd_q;
  logic [1:0] mode_q;
  logic       lb_q;

  wire wr_a   = wr_en && addr == A_LCRA;
  wire wr_b   = wr_en && addr == A_LCRB;
  wire wr_s   = wr_en && addr == A_STAT;
  wire clr_go = wr_s && wdata[7] && ptr_q == 3'd0;

  wire set_abt = (wr_a && wdata[2]) || (underrun_i && !dd_q) || overrun_i || frame_err_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      {frm_q, crc_q, abt_q} <= '0;
      {fiforst_q, fast_q, gp_q, rawtx_q, abort_q, dd_q} <= '0;
      mode_q <= '0;
      lb_q   <= 1'b0;
    end else begin
      if (wr_s && !wdata[7]) ptr_q <= wdata[2:0];
      frm_q <= frame_err_i || (frm_q && !(clr_go && wdata[4]));
      crc_q <= crc_err_i   || (crc_q && !(clr_go && wdata[3]));
      abt_q <= set_abt     || (abt_q && !(clr_go && wdata[2]));

      fast_q  <= wr_a ? wdata[6] : fast_q;
      gp_q    <= wr_a ? wdata[5] : gp_q;
      rawtx_q <= wr_a ? wdata[4] : rawtx_q;

      if (fifo_init_done_i) fiforst_q <= 1'b0;
      else if (wr_a)        fiforst_q <= wdata[7];

      if (eof_i)      abort_q <= 1'b0;
      else if (wr_a)  abort_q <= wdata[2];

      if (eof_i && fifo_empty_i)    dd_q <= 1'b0;
      else if (tc_i && mode_q == 2'b10) dd_q <= 1'b1;
      else if (wr_a)                dd_q <= wdata[1];

      if (cir_done_i) mode_q <= 2'b00;
      else if (wr_b)  mode_q <= wdata[7:6];

      if (wr_b) lb_q <= wdata[0] && mode_q == 2'b00 && wdata[7:6] == 2'b00;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == A_LCRA)
      rdata = {fiforst_q, fast_q, gp_q, rawtx_q, raw_rx_i, abort_q, dd_q, 1'b0};
    else if (addr == A_LCRB)
      rdata = {mode_q, 5'b0, lb_q};
    else if (addr == A_STAT) begin
      if (ptr_q == 3'd0)      rdata = {3'b0, frm_q, crc_q, abt_q, 2'b0};
      else if (ptr_q == 3'd1) rdata = {5'b0, lb_q, mode_q != 2'b00, raw_rx_i};
    end
  end

  assign fifo_reset_o = fiforst_q;
  assign fast_o       = fast_q;
  assign gp_o         = gp_q;
  assign raw_tx_o     = rawtx_q;
  assign abort_o      = abort_q;
  assign data_done_o  = dd_q;
  assign mode_o       = mode_q;
  assign loopback_o   = lb_q;

  a_r3_crc_latch: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_i |=> rdata_stat0_crc());

  function automatic logic rdata_stat0_crc();
    return crc_q;
  endfunction

  a_r4_underrun_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_i && !data_done_o) |=> abt_q);

  a_r5_frame_err: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_i |=> (frm_q && abt_q));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_q && !(wr_en && addr == A_STAT && wdata[7])) |=> crc_q);

  a_r8_eof_abort: assert property (@(posedge clk) disable iff (!rst_n)
    eof_i |=> !abort_o);

  a_r10_fifo_init: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_init_done_i |=> !fifo_reset_o);

  a_r11_cir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cir_done_i |=> mode_o == 2'b00);

  a_r12_lb_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_o |-> mode_o == 2'b00);

  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> $stable(ptr_q));

endmodule

// File: tb/ir_line_regs_tb.sv
module ir_line_regs_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, wr_en, raw_rx, fempty;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, ev;
  logic       fiforst, fast, gp, rawtx, abort_o, dd_o, lb_o;
  logic [1:0] mode_o;

  ir_line_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .raw_rx_i(raw_rx), .fifo_empty_i(fempty),
    .crc_err_i(ev[0]), .frame_err_i(ev[1]), .overrun_i(ev[2]), .underrun_i(ev[3]),
    .tc_i(ev[4]), .eof_i(ev[5]), .fifo_init_done_i(ev[6]), .cir_done_i(ev[7]),
    .fifo_reset_o(fiforst), .fast_o(fast), .gp_o(gp), .raw_tx_o(rawtx),
    .abort_o(abort_o), .data_done_o(dd_o), .mode_o(mode_o), .loopback_o(lb_o));

  int tests = 0, fails = 0;
  bit finished = 0;

  // behavioural reference
  int m_ptr, m_mode;
  bit m_frm, m_crc, m_abt, m_fr, m_fast, m_gp, m_tx, m_ab, m_dd, m_lb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_mode = 0;
      {m_frm, m_crc, m_abt, m_fr, m_fast, m_gp, m_tx, m_ab, m_dd, m_lb} = '0;
    end else begin
      int old_mode;
      bit old_dd;
      old_mode = m_mode; old_dd = m_dd;
      if (wr_en && addr == 3'd6) begin
        if (!wdata[7]) m_ptr = int'(wdata[2:0]);
        else if (m_ptr == 0) begin
          if (wdata[4]) m_frm = 0;
          if (wdata[3]) m_crc = 0;
          if (wdata[2]) m_abt = 0;
        end
      end
      if (wr_en && addr == 3'd4) begin
        m_fr = wdata[7]; m_fast = wdata[6]; m_gp = wdata[5];
        m_tx = wdata[4]; m_ab = wdata[2]; m_dd = wdata[1];
        if (wdata[2]) m_abt = 1;
      end
      if (wr_en && addr == 3'd5) begin
        m_lb = wdata[0] && old_mode == 0 && wdata[7:6] == 0;
        m_mode = int'(wdata[7:6]);
      end
      if (ev[0]) m_crc = 1;
      if (ev[1]) begin m_frm = 1; m_abt = 1; end
      if (ev[2]) m_abt = 1;
      if (ev[3] && !old_dd) m_abt = 1;
      if (ev[4] && old_mode == 2) m_dd = 1;
      if (ev[5]) m_ab = 0;
      if (ev[5] && fempty) m_dd = 0;
      if (ev[6]) m_fr = 0;
      if (ev[7]) m_mode = 0;
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (addr)
      3'd4: return {m_fr, m_fast, m_gp, m_tx, raw_rx, m_ab, m_dd, 1'b0};
      3'd5: return {m_mode[1:0], 5'b0, m_lb};
      3'd6: if (m_ptr == 0) return {3'b0, m_frm, m_crc, m_abt, 2'b0};
            else if (m_ptr == 1) return {5'b0, m_lb, m_mode != 0, raw_rx};
            else return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] e;
    string t;
    e = exp_rdata();
    t = (addr == 3'd6) ? "R6" : (addr == 3'd4) ? "R7" : (addr == 3'd5) ? "R11" : "R2";
    chk(rdata == e, t, rdata, e);
    chk(fiforst == m_fr, "R10", fiforst, m_fr);
    chk({fast, gp, rawtx} == {m_fast, m_gp, m_tx}, "R7", {fast, gp, rawtx}, {m_fast, m_gp, m_tx});
    chk(abort_o == m_ab, "R8", abort_o, m_ab);
    chk(dd_o == m_dd, "R9", dd_o, m_dd);
    chk(int'(mode_o) == m_mode, "R11", mode_o, m_mode);
    chk(lb_o == m_lb, "R12", lb_o, m_lb);
  endtask

  task automatic step(input bit w, input logic [2:0] a, input logic [7:0] d, input logic [7:0] e);
    wr_en = w; addr = a; wdata = d; ev = e;
    @(negedge clk);
    compare();
  endtask

  task automatic show(input logic [2:0] a);
    step(0, a, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; addr = 3'd6; wdata = 0; ev = 0; raw_rx = 0; fempty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(rdata == 8'h00, "R1", rdata, 0);
    chk({fiforst, fast, gp, rawtx, abort_o, dd_o, mode_o, lb_o} == 9'd0, "R1",
        {fiforst, fast, gp, rawtx, abort_o, dd_o, mode_o, lb_o}, 0);
    // R3: CRC latch
    step(0, 3'd6, 8'h00, 8'h01);
    show(3'd6);
    chk(rdata == 8'h08, "R3", rdata, 8'h08);
    step(1, 3'd6, 8'h88, 8'h00);
    chk(rdata == 8'h00, "R6", rdata, 0);
    // R4: underrun masked by data-done, then not
    step(1, 3'd4, 8'h02, 8'h00);
    step(0, 3'd6, 8'h00, 8'h08);
    show(3'd6);
    chk(rdata == 8'h00, "R4", rdata, 0);
    step(1, 3'd4, 8'h00, 8'h00);
    step(0, 3'd6, 8'h00, 8'h08);
    show(3'd6);
    chk(rdata == 8'h04, "R4", rdata, 8'h04);
    // R5: framing error sets both bits
    step(1, 3'd6, 8'hFF, 8'h00);
    step(0, 3'd6, 8'h00, 8'h02);
    show(3'd6);
    chk(rdata == 8'h14, "R5", rdata, 8'h14);
    // R13: set beats clear in the same cycle
    step(1, 3'd6, 8'h9C, 8'h01);
    chk(rdata == 8'h08, "R13", rdata, 8'h08);
    // R12: loopback refused under nonzero stored mode
    step(1, 3'd5, 8'h40, 8'h00);
    step(1, 3'd5, 8'h01, 8'h00);
    chk(lb_o == 1'b0, "R12", lb_o, 0);
    step(1, 3'd5, 8'h01, 8'h00);
    chk(lb_o == 1'b1, "R12", lb_o, 1);
    // R2: pointer selects live register, upper pointers read zero
    raw_rx = 1;
    step(1, 3'd6, 8'h01, 8'h00);
    chk(rdata == 8'h05, "R2", rdata, 8'h05);
    step(1, 3'd6, 8'h05, 8'h00);
    chk(rdata == 8'h00, "R2", rdata, 0);
    step(1, 3'd6, 8'h00, 8'h00);
    // random phase, compared every cycle against the model
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] e, d;
      logic [2:0] a;
      int r;
      e = 0;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 19) == 0) e[b] = 1'b1;
      r = $urandom_range(0, 9);
      a = (r < 3) ? 3'd4 : (r < 6) ? 3'd5 : (r < 9) ? 3'd6 : 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd5 && $urandom_range(0, 2) == 0) d[7:6] = 2'b00;
      if (a == 3'd6 && $urandom_range(0, 1) == 0) d[2:0] = 3'($urandom_range(0, 1));
      raw_rx = 1'($urandom);
      fempty = 1'($urandom);
      step($urandom_range(0, 9) < 3, a, d, e);
    end
    finish_run();
  end
endmodule